// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address by first sorting the address into one of several fixed regions of the address space. Two kernel windows in the upper half are translated without any lookup: the physical address is the virtual address minus the window base. All other regions are sent to an external translation lookaside buffer (TLB). The block raises a lookup request for them and passes the TLB's physical address and write permission through. The exception is the low region while the error-level flag is set: there the address maps to itself with read and write permission.

When an access cannot complete, the block reports a fault in the same cycle. The fault is an address error if user code touches the upper half. Otherwise it is a TLB miss, an invalid entry or a write to a read-only page. Each kind has its own exception code, and a miss also raises a refill indication. On the clock edge that ends a faulting request, three fault registers are loaded: the faulting address, a context word that holds the page-pair number, and an entry-high word that holds the page-pair number beside the current address-space identifier. Software can read and write all three through a small register port.

Top module: `vaddr_xlate`

## Requirements
- R1: While `user_mode` is 1, a valid request with `req_vaddr[31]` = 1 faults with code 4 when `req_write` = 0 or code 5 when `req_write` = 1, and `tlb_lookup` stays 0.
- R2: A valid request below 0x80000000 with `err_level` = 0 raises `tlb_lookup`. With `err_level` = 1 it gives `paddr` = `req_vaddr`, both permissions 1, and no lookup.
- R3: A valid request (not faulted by R1) in 0x80000000..0x9FFFFFFF gives `paddr` = vaddr − 0x80000000. One in 0xA0000000..0xBFFFFFFF gives vaddr − 0xA0000000. Both have read and write permission 1, no lookup and no fault.
- R4: A valid request (not faulted by R1) at 0xC0000000 or above raises `tlb_lookup`.
- R5: For a looked-up address, `tlb_status` is decoded as 0 hit, 1 miss, 2 invalid, 3 write to read-only. A hit gives `paddr` = `tlb_paddr`, `perm_rd` = 1 and `perm_wr` = `tlb_writable`. A miss or invalid faults with code 2 (read) or 3 (write). Status 3 faults with code 1. Without a fault, `exc_code` is 0.
- R6: `refill` is 1 only for a faulting TLB miss.
- R7: On the clock edge that ends a faulting valid request, the bad-address register (select 0) takes `req_vaddr`.
- R8: On that edge, the context register (select 1) keeps bits 31:23, takes vaddr bits 31:13 into bits 22:4, and clears bits 3:0.
- R9: On that edge, the entry-high register (select 2) keeps bits 7:0, takes vaddr bits 31:13 into bits 31:13, and clears bits 12:8.
- R10: `reg_rdata` shows the register chosen by `reg_sel`, and select 3 reads 0. A write with `reg_wr_en` lands on the next edge, unless a fault is taken in that cycle; the fault update then wins and the write is dropped.
- R11: The registers hold their value when a request does not fault or `req_valid` is 0.
- R12: After reset all three registers are 0, and with `req_valid` = 0, `fault`, `refill`, `tlb_lookup`, `perm_rd` and `perm_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| user_mode | input | 1 | Request issued in user mode |
| err_level | input | 1 | Error level active (low region maps to itself) |
| tlb_lookup | output | 1 | Address needs the TLB result |
| tlb_status | input | 2 | TLB outcome: 0 hit, 1 miss, 2 invalid, 3 read-only |
| tlb_paddr | input | 32 | Physical address from the TLB on a hit |
| tlb_writable | input | 1 | TLB page writable |
| paddr | output | 32 | Physical address, 0 on fault |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| fault | output | 1 | Request faults |
| exc_code | output | 5 | Exception code, 0 when no fault |
| refill | output | 1 | Fault is a TLB miss |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Register select: 0 bad address, 1 context, 2 entry high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |

## Verification
A wrong region decode shows at once, in the same cycle, as a wrong `paddr`, a lookup request that should not be there, or a missing fault. A wrong exception or refill classification also appears in that cycle. The fault registers are only visible through the register port. A field slip in context or entry-high, or an identifier that is lost, therefore appears at the first read after the faulting edge, so the bench reads all three registers after every fault it provokes.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the segmented address translator.
// Assumes a 32-bit virtual and physical address space.
package xlate_pkg;
    localparam int VA_W = 32;

    localparam logic [VA_W-1:0] SEG_K0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] SEG_K1_BASE = 32'hA000_0000;
    localparam logic [VA_W-1:0] SEG_HI_BASE = 32'hC000_0000;

    typedef enum logic [1:0] {
        TLB_HIT     = 2'd0,
        TLB_MISS    = 2'd1,
        TLB_INVALID = 2'd2,
        TLB_RO      = 2'd3
    } tlb_status_e;

    typedef enum logic [1:0] {
        ROUTE_DIRECT = 2'd0,
        ROUTE_TLB    = 2'd1,
        ROUTE_REJECT = 2'd2
    } route_e;

    localparam logic [4:0] EXC_NONE    = 5'd0;
    localparam logic [4:0] EXC_MOD     = 5'd1;
    localparam logic [4:0] EXC_TLB_LD  = 5'd2;
    localparam logic [4:0] EXC_TLB_ST  = 5'd3;
    localparam logic [4:0] EXC_ADDR_LD = 5'd4;
    localparam logic [4:0] EXC_ADDR_ST = 5'd5;
endpackage

// File: rtl/xlate_seg_decode.sv
// Region decoder: sorts a virtual address into reject, direct or TLB routing
// and computes the physical address for the directly translated regions.
// Assumes the window bases in xlate_pkg are ordered K0 < K1 < HI.
module xlate_seg_decode
    import xlate_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            user_mode,
    input  logic            err_level,
    output route_e          route,
    output logic [VA_W-1:0] direct_pa
);
    // Classify the address and compute its direct translation.
    always_comb begin
        route     = ROUTE_DIRECT;
        direct_pa = '0;
        if (user_mode && (vaddr >= SEG_K0_BASE)) begin
            route = ROUTE_REJECT;
        end else if (vaddr < SEG_K0_BASE) begin
            if (err_level) begin
                direct_pa = vaddr;
            end else begin
                route = ROUTE_TLB;
            end
        end else if (vaddr < SEG_K1_BASE) begin
            direct_pa = vaddr - SEG_K0_BASE;
        end else if (vaddr < SEG_HI_BASE) begin
            direct_pa = vaddr - SEG_K1_BASE;
        end else begin
            route = ROUTE_TLB;
        end
    end
endmodule

// File: rtl/xlate_fault_map.sv
// Fault classifier: turns the routing decision and the TLB outcome into a
// fault flag, an exception code and a refill indication.
// Assumes tlb_status is only meaningful when route is ROUTE_TLB.
module xlate_fault_map
    import xlate_pkg::*;
(
    input  logic        valid,
    input  logic        is_write,
    input  route_e      route,
    input  tlb_status_e tlb_st,
    output logic        fault,
    output logic [4:0]  exc,
    output logic        refill
);
    // Pick the exception for the current request.
    always_comb begin
        fault  = 1'b0;
        exc    = EXC_NONE;
        refill = 1'b0;
        if (valid) begin
            if (route == ROUTE_REJECT) begin
                fault = 1'b1;
                exc   = is_write ? EXC_ADDR_ST : EXC_ADDR_LD;
            end else if (route == ROUTE_TLB) begin
                case (tlb_st)
                    TLB_MISS: begin
                        fault  = 1'b1;
                        exc    = is_write ? EXC_TLB_ST : EXC_TLB_LD;
                        refill = 1'b1;
                    end
                    TLB_INVALID: begin
                        fault = 1'b1;
                        exc   = is_write ? EXC_TLB_ST : EXC_TLB_LD;
                    end
                    TLB_RO: begin
                        fault = 1'b1;
                        exc   = EXC_MOD;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/xlate_fault_regs.sv
// Fault register file: bad address, context and entry-high words. A fault
// loads all three on the edge; otherwise a register-port write may land.
// Assumes PAGE_BITS + 1 > ASID_W so the entry-high gap field is not empty.
module xlate_fault_regs
    import xlate_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int CTX_LO    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_fault,
    input  logic [VA_W-1:0] fault_va,
    input  logic            wr_en,
    input  logic [1:0]      sel,
    input  logic [VA_W-1:0] wdata,
    output logic [VA_W-1:0] rdata,
    output logic [VA_W-1:0] bad_q,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    localparam int VPN2_LSB = PAGE_BITS + 1;
    localparam int VPN2_W   = VA_W - VPN2_LSB;
    localparam int CTX_TOP  = CTX_LO + VPN2_W;
    localparam int GAP_W    = VPN2_LSB - ASID_W;

    logic [VPN2_W-1:0] vpn2;
    assign vpn2 = fault_va[VA_W-1:VPN2_LSB];

    // Update on fault first, then apply a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= '0;
            ctx_q <= '0;
            ehi_q <= '0;
        end else if (take_fault) begin
            bad_q <= fault_va;
            ctx_q <= {ctx_q[VA_W-1:CTX_TOP], vpn2, {CTX_LO{1'b0}}};
            ehi_q <= {vpn2, {GAP_W{1'b0}}, ehi_q[ASID_W-1:0]};
        end else if (wr_en) begin
            case (sel)
                2'd0: bad_q <= wdata;
                2'd1: ctx_q <= wdata;
                2'd2: ehi_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer for the register port.
    always_comb begin
        case (sel)
            2'd0:    rdata = bad_q;
            2'd1:    rdata = ctx_q;
            2'd2:    rdata = ehi_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/vaddr_xlate.sv
// Top of the segmented address translator. Translation and fault reporting
// are combinational on the request; the fault registers update on the edge.
// Assumes the TLB answers tlb_status/tlb_paddr in the cycle tlb_lookup is high.
module vaddr_xlate
    import xlate_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        user_mode,
    input  logic        err_level,
    output logic        tlb_lookup,
    input  logic [1:0]  tlb_status,
    input  logic [31:0] tlb_paddr,
    input  logic        tlb_writable,
    output logic [31:0] paddr,
    output logic        perm_rd,
    output logic        perm_wr,
    output logic        fault,
    output logic [4:0]  exc_code,
    output logic        refill,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    route_e      route;
    logic [31:0] direct_pa;
    logic [31:0] bad_q;
    logic [31:0] ctx_q;
    logic [31:0] ehi_q;

    xlate_seg_decode u_dec (
        .vaddr     (req_vaddr),
        .user_mode (user_mode),
        .err_level (err_level),
        .route     (route),
        .direct_pa (direct_pa)
    );

    xlate_fault_map u_map (
        .valid    (req_valid),
        .is_write (req_write),
        .route    (route),
        .tlb_st   (tlb_status_e'(tlb_status)),
        .fault    (fault),
        .exc      (exc_code),
        .refill   (refill)
    );

    xlate_fault_regs #(
        .PAGE_BITS (PAGE_BITS),
        .ASID_W    (ASID_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_fault (fault),
        .fault_va   (req_vaddr),
        .wr_en      (reg_wr_en),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .bad_q      (bad_q),
        .ctx_q      (ctx_q),
        .ehi_q      (ehi_q)
    );

    // Drive the result: lookup request, address and permissions.
    always_comb begin
        tlb_lookup = req_valid && (route == ROUTE_TLB);
        paddr      = '0;
        perm_rd    = 1'b0;
        perm_wr    = 1'b0;
        if (req_valid && !fault) begin
            perm_rd = 1'b1;
            if (route == ROUTE_TLB) begin
                paddr   = tlb_paddr;
                perm_wr = tlb_writable;
            end else begin
                paddr   = direct_pa;
                perm_wr = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlate_checker.sv
// Property checker for vaddr_xlate, attached with bind.
// Assumes the fault registers are reachable by name in the top module.
module xlate_checker #(
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic        user_mode,
    input logic        tlb_lookup,
    input logic [31:0] paddr,
    input logic        fault,
    input logic [4:0]  exc_code,
    input logic        refill,
    input logic [31:0] bad_q,
    input logic [31:0] ctx_q,
    input logic [31:0] ehi_q
);
    localparam int V2L = PAGE_BITS + 1;
    localparam int V2W = 32 - V2L;

    AST_USER_HIGH_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && req_vaddr[31]) |-> (fault && !tlb_lookup && exc_code == (req_write ? 5'd5 : 5'd4))); // R1
    AST_KSEG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !user_mode && req_vaddr[31:30] == 2'b10) |-> (!fault && !tlb_lookup && paddr == {3'b000, req_vaddr[28:0]})); // R3
    AST_HIGH_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !user_mode && req_vaddr[31:30] == 2'b11) |-> tlb_lookup); // R4
    AST_REFILL_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        refill |-> (fault && (exc_code == 5'd2 || exc_code == 5'd3))); // R6
    AST_BAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fault) |=> (bad_q == $past(req_vaddr))); // R7
    AST_CTX_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fault) |=> (ctx_q[31:4+V2W] == $past(ctx_q[31:4+V2W]) && ctx_q[4 +: V2W] == $past(req_vaddr[31:V2L]) && ctx_q[3:0] == 4'd0)); // R8
    AST_EHI_ASID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fault) |=> (ehi_q[ASID_W-1:0] == $past(ehi_q[ASID_W-1:0]) && ehi_q[31:V2L] == $past(req_vaddr[31:V2L]))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!fault && !refill && !tlb_lookup)); // R12
endmodule

bind vaddr_xlate xlate_checker #(.PAGE_BITS(PAGE_BITS), .ASID_W(ASID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .user_mode  (user_mode),
    .tlb_lookup (tlb_lookup),
    .paddr      (paddr),
    .fault      (fault),
    .exc_code   (exc_code),
    .refill     (refill),
    .bad_q      (bad_q),
    .ctx_q      (ctx_q),
    .ehi_q      (ehi_q)
);

// File: tb/sim_vaddr_xlate.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module sim_vaddr_xlate;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, user_mode = 1'b0, err_level = 1'b0;
    logic [31:0] req_vaddr = '0, tlb_paddr = '0, reg_wdata = '0;
    logic [1:0]  tlb_status = '0, reg_sel = '0;
    logic        tlb_writable = 1'b0, reg_wr_en = 1'b0;
    logic        tlb_lookup, perm_rd, perm_wr, fault, refill;
    logic [31:0] paddr, reg_rdata;
    logic [4:0]  exc_code;

    vaddr_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .user_mode(user_mode), .err_level(err_level),
        .tlb_lookup(tlb_lookup), .tlb_status(tlb_status), .tlb_paddr(tlb_paddr),
        .tlb_writable(tlb_writable), .paddr(paddr), .perm_rd(perm_rd),
        .perm_wr(perm_wr), .fault(fault), .exc_code(exc_code), .refill(refill),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    typedef struct {
        logic [31:0] pa;
        logic        rd, wr, flt, rf, lk;
        logic [4:0]  exc;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: apply one request and queue its expected result.
    task automatic issue(string tag, logic [31:0] va, logic wr, logic um, logic el,
                         logic [1:0] st, logic [31:0] tpa, logic tw);
        exp_t e;
        logic bad, tlb;
        logic [31:0] dpa;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; user_mode = um;
        err_level = el; tlb_status = st; tlb_paddr = tpa; tlb_writable = tw;
        reg_wr_en = 1'b0;
        bad = um && (va >= 32'h8000_0000);
        tlb = 1'b0; dpa = '0;
        if (!bad) begin
            if (va < 32'h8000_0000) begin
                if (el) dpa = va; else tlb = 1'b1;
            end else if (va < 32'hA000_0000) dpa = va - 32'h8000_0000;
            else if (va < 32'hC000_0000) dpa = va - 32'hA000_0000;
            else tlb = 1'b1;
        end
        e = '{pa: '0, rd: 1'b0, wr: 1'b0, flt: 1'b0, rf: 1'b0, lk: tlb, exc: 5'd0, tag: tag};
        if (bad) begin
            e.flt = 1'b1; e.exc = wr ? 5'd5 : 5'd4;
        end else if (tlb) begin
            case (st)
                2'd0: begin e.pa = tpa; e.rd = 1'b1; e.wr = tw; end
                2'd1: begin e.flt = 1'b1; e.exc = wr ? 5'd3 : 5'd2; e.rf = 1'b1; end
                2'd2: begin e.flt = 1'b1; e.exc = wr ? 5'd3 : 5'd2; end
                default: begin e.flt = 1'b1; e.exc = 5'd1; end
            endcase
        end else begin
            e.pa = dpa; e.rd = 1'b1; e.wr = 1'b1;
        end
        if (e.flt) begin
            m_bad = va;
            m_ctx = {m_ctx[31:23], va[31:13], 4'b0};
            m_ehi = {va[31:13], 5'b0, m_ehi[7:0]};
        end
        q.push_back(e);
    endtask

    task automatic wr_reg(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        req_valid = 1'b0; reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
        case (sel)
            2'd0: m_bad = val;
            2'd1: m_ctx = val;
            2'd2: m_ehi = val;
            default: ;
        endcase
    endtask

    task automatic rd_reg(logic [1:0] sel, logic [31:0] expv, string tag);
        @(negedge clk);
        req_valid = 1'b0; reg_wr_en = 1'b0; reg_sel = sel;
        #1 chk(tag, reg_rdata, expv);
    endtask

    task automatic rd_all(string tag);
        rd_reg(2'd0, m_bad, {tag, " R7 bad address"});
        rd_reg(2'd1, m_ctx, {tag, " R8 context"});
        rd_reg(2'd2, m_ehi, {tag, " R9 entry high"});
    endtask

    // Monitor: compare the oldest expected item just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " paddr"}, paddr, e.pa);
                chk({e.tag, " perm_rd"}, {31'b0, perm_rd}, {31'b0, e.rd});
                chk({e.tag, " perm_wr"}, {31'b0, perm_wr}, {31'b0, e.wr});
                chk({e.tag, " fault"}, {31'b0, fault}, {31'b0, e.flt});
                chk({e.tag, " exc_code"}, {27'b0, exc_code}, {27'b0, e.exc});
                chk({e.tag, " refill R6"}, {31'b0, refill}, {31'b0, e.rf});
                chk({e.tag, " tlb_lookup"}, {31'b0, tlb_lookup}, {31'b0, e.lk});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual expired expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R12: reset state and quiet outputs while idle
        #1 chk("R12 idle fault", {31'b0, fault}, 32'd0);
        chk("R12 idle lookup", {31'b0, tlb_lookup}, 32'd0);
        chk("R12 idle perm_rd", {31'b0, perm_rd}, 32'd0);
        rd_all("R12 reset");
        rd_reg(2'd3, 32'd0, "R10 select 3");

        issue("R2 low tlb hit", 32'h0040_1234, 1'b0, 1'b0, 1'b0, 2'd0, 32'h1234_5234, 1'b1);
        issue("R2 low tlb hit ro", 32'h0040_1234, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0777_0234, 1'b0);
        issue("R2 err level identity", 32'h7FFF_FFFC, 1'b1, 1'b0, 1'b1, 2'd1, 32'h0, 1'b0);
        issue("R3 window0", 32'h8000_1234, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0);
        issue("R3 window0 top", 32'h9FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0);
        issue("R3 window1", 32'hA000_1234, 1'b1, 1'b0, 1'b1, 2'd1, 32'h0, 1'b0);
        issue("R3 window1 top", 32'hBFFF_FFF0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        issue("R4 high hit", 32'hC000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0ABC_D000, 1'b1);
        issue("R4 high hit top", 32'hFFFF_F004, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_2004, 1'b1);
        // R11: no faults so far, registers unchanged
        rd_all("R11 no fault");

        // R11: fault conditions with req_valid low
        @(negedge clk);
        req_valid = 1'b0; user_mode = 1'b1; req_vaddr = 32'hFFFF_0000; tlb_status = 2'd1;
        #1 chk("R11 idle no fault", {31'b0, fault}, 32'd0);
        @(negedge clk);
        rd_all("R11 invalid request");

        wr_reg(2'd2, 32'hFFFF_FF5A);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        wr_reg(2'd0, 32'h1357_9BDF);
        rd_all("R10 software write");

        issue("R1 user load high", 32'h8000_0010, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b1);
        rd_all("R1 fault regs");
        issue("R1 user store high", 32'hF123_4567, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 1'b1);
        rd_all("R1 store fault regs");
        issue("R5 miss load", 32'h1234_5678, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        issue("R5 miss store", 32'hC765_4321, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0);
        rd_all("R5 miss regs");
        issue("R5 invalid load", 32'h0000_3000, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        issue("R5 invalid store", 32'hE000_2000, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        issue("R5 read-only store", 32'h5555_AAAA, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0);
        rd_all("R9 after read-only fault");

        // R10: write in the same cycle as a fault is dropped
        issue("R10 fault vs write", 32'hDEAD_B000, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
        reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0BAD_0BAD;
        rd_all("R10 fault wins");

        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule